// File: doc/BRIEF.md
# Saturating Signed Lane ALU

This unit works on a packed vector of signed lanes. Each lane runs one of four operations chosen by a shared opcode: absolute value, negation, addition or subtraction. When the true result does not fit the lane, the lane is clamped to the nearest signed limit instead of wrapping. A parameter sets the lane width to 8, 16, 32 or 64 bits. A second parameter sets how many lanes the vector holds.

The operands are captured with a valid strobe. The clamped result vector is registered, and so is a per-lane vector that marks which lanes clamped. A single sticky flag gathers every clamp from every operation. It stays set until a dedicated clear input is pulsed. The flag lets software run a long sequence of vector operations and then ask once whether any precision was lost.

Top module: `sat_vec_alu`

## Requirements
- R1: With opcode 0 (absolute value), a negative lane other than the most negative value is replaced by its two's-complement negation, and a non-negative lane passes through unchanged.
- R2: With opcode 0, a lane holding the most negative value yields the most positive value, and that lane's saturation bit is set.
- R3: With opcode 1 (negate), every lane is two's-complement negated, except that the most negative value yields the most positive value with that lane's saturation bit set.
- R4: With opcode 2 (add), a lane overflows when the two operands share a sign and the wrapped sum has the other sign. An overflowing lane whose wrapped sum is negative becomes the most positive value, and one whose wrapped sum is non-negative becomes the most negative value. Either way the lane's saturation bit is set.
- R5: With opcode 3 (subtract), a lane overflows when the operands differ in sign and the wrapped difference's sign differs from the first operand's sign. The clamp direction and the saturation bit follow the rule of R4.
- R6: Lanes are independent. Lane i occupies bits [i*LANE_W +: LANE_W] of every vector, and bit i of the per-lane saturation output belongs to lane i.
- R7: The result and per-lane saturation outputs take new values on the clock edge at which the valid strobe is high, and hold their values while the strobe is low.
- R8: The sticky flag is set by any lane saturating in a valid operation. An operation in which no lane saturates never clears it.
- R9: Pulsing the clear input drops the sticky flag on the next edge. If a saturating valid operation arrives in the same cycle as the clear, the flag ends up set.
- R10: A synchronous active-high reset zeroes the result, the per-lane saturation vector and the sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Captures the operands and opcode on this edge |
| op | input | 2 | Operation: 0 abs, 1 negate, 2 add, 3 subtract |
| src_a | input | LANES*LANE_W | First operand vector |
| src_b | input | LANES*LANE_W | Second operand vector (add and subtract only) |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| res_q | output | LANES*LANE_W | Registered clamped result |
| lane_sat_q | output | LANES | Registered per-lane saturation bits of the last operation |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The immediate lane checks assume that the operands and opcode are driven to known values from the first evaluation on. The stimulus therefore sets all inputs before reset is released and changes them only on the falling clock edge. The clocked properties on the flag assume that the clear and the valid strobe are ordinary single-cycle levels sampled at the rising edge. The bench drives both from tasks that settle them half a cycle before the edge. The tests deliberately overlap them once to reach the set-wins case.

// File: rtl/sat_lane_pkg.sv
`timescale 1ns/1ps
package sat_lane_pkg;
  typedef enum logic [1:0] {
    OP_ABS = 2'd0,
    OP_NEG = 2'd1,
    OP_ADD = 2'd2,
    OP_SUB = 2'd3
  } lane_op_e;
endpackage

// File: rtl/sat_lane_unit.sv
`timescale 1ns/1ps
module sat_lane_unit
  import sat_lane_pkg::*;
#(
  parameter int W = 8
) (
  input  lane_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output logic           sat
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] neg_a, sum_w, dif_w;
  logic a_is_min, add_ovf, sub_ovf;

  always_comb begin
    neg_a    = ~a + 1'b1;
    sum_w    = a + b;
    dif_w    = a - b;
    a_is_min = (a == MINV);
    add_ovf  = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);
    sub_ovf  = (a[W-1] != b[W-1]) && (dif_w[W-1] != a[W-1]);
  end

  always_comb begin
    y   = a;
    sat = 1'b0;
    unique case (op)
      OP_ABS: begin
        if (a_is_min) begin
          y = MAXV; sat = 1'b1;
        end else if (a[W-1]) begin
          y = neg_a;
        end
      end
      OP_NEG: begin
        if (a_is_min) begin
          y = MAXV; sat = 1'b1;
        end else begin
          y = neg_a;
        end
      end
      OP_ADD: begin
        y = sum_w;
        if (add_ovf) begin
          y = sum_w[W-1] ? MAXV : MINV; sat = 1'b1;
        end
      end
      OP_SUB: begin
        y = dif_w;
        if (sub_ovf) begin
          y = dif_w[W-1] ? MAXV : MINV; sat = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // Lane-level checks
  always_comb begin
    if (op == OP_ABS)
      p_abs_nonneg_r1: assert (y[W-1] == 1'b0);
    if (sat)
      p_clamp_limit_r4: assert (y == MAXV || y == MINV);
    if (op == OP_NEG && a_is_min)
      p_neg_min_r3: assert (sat && y == MAXV);
  end
endmodule

// File: rtl/sat_lane_array.sv
`timescale 1ns/1ps
module sat_lane_array
  import sat_lane_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
) (
  input  lane_op_e          op,
  input  logic [VEC_W-1:0]  a_vec,
  input  logic [VEC_W-1:0]  b_vec,
  output logic [VEC_W-1:0]  y_vec,
  output logic [LANES-1:0]  sat_vec
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sat_lane_unit #(.W(LANE_W)) u_lane (
      .op  (op),
      .a   (a_vec[i*LANE_W +: LANE_W]),
      .b   (b_vec[i*LANE_W +: LANE_W]),
      .y   (y_vec[i*LANE_W +: LANE_W]),
      .sat (sat_vec[i])
    );
  end
endmodule

// File: rtl/sat_flag_reg.sv
`timescale 1ns/1ps
module sat_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic any_sat,
  input  logic clr,
  output logic flag_q
);
  logic set_now;
  assign set_now = upd & any_sat;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  p_set_r8: assert property (@(posedge clk) disable iff (rst)
    (upd && any_sat) |=> flag_q);
  p_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !(upd && any_sat)) |=> !flag_q);
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!upd && !clr) |=> $stable(flag_q));
endmodule

// File: rtl/sat_vec_alu.sv
`timescale 1ns/1ps
module sat_vec_alu
  import sat_lane_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic             flag_clr,
  output logic [VEC_W-1:0] res_q,
  output logic [LANES-1:0] lane_sat_q,
  output logic             sat_sticky
);
  logic [VEC_W-1:0] res_c;
  logic [LANES-1:0] sat_c;
  lane_op_e         op_e;

  assign op_e = lane_op_e'(op);

  sat_lane_array #(.LANE_W(LANE_W), .LANES(LANES)) u_array (
    .op      (op_e),
    .a_vec   (src_a),
    .b_vec   (src_b),
    .y_vec   (res_c),
    .sat_vec (sat_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q      <= '0;
      lane_sat_q <= '0;
    end else if (in_valid) begin
      res_q      <= res_c;
      lane_sat_q <= sat_c;
    end
  end

  sat_flag_reg u_flag (
    .clk     (clk),
    .rst     (rst),
    .upd     (in_valid),
    .any_sat (|sat_c),
    .clr     (flag_clr),
    .flag_q  (sat_sticky)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_q) && $stable(lane_sat_q)));
  p_lane_to_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && |sat_c) |=> (sat_sticky && lane_sat_q != '0));
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (res_q == '0 && lane_sat_q == '0 && !sat_sticky));
endmodule

// File: tb/sat_vec_alu_test.sv
`timescale 1ns/1ps
module sat_vec_alu_test;
  localparam int LW = 8;
  localparam int NL = 4;
  localparam int VW = LW * NL;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [VW-1:0] src_a = '0, src_b = '0;
  logic flag_clr = 1'b0;
  logic [VW-1:0] res_q;
  logic [NL-1:0] lane_sat_q;
  logic sat_sticky;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_sticky = 1'b0;

  always #2 clk = ~clk;

  sat_vec_alu #(.LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .flag_clr(flag_clr),
    .res_q(res_q), .lane_sat_q(lane_sat_q), .sat_sticky(sat_sticky)
  );

  // {op, a, b}
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h80FF017F, 32'h00000000},
    {2'd0, 32'h81009C05, 32'h00000000},
    {2'd1, 32'h807F00FF, 32'h00000000},
    {2'd1, 32'h810140C0, 32'h00000000},
    {2'd2, 32'h7F801040, 32'h01FF2040},
    {2'd2, 32'h807FF005, 32'h8081F0FB},
    {2'd3, 32'h807F0500, 32'h01FF0A80},
    {2'd3, 32'h7F8030C0, 32'h7F805040},
    {2'd2, 32'h00000000, 32'h00000000},
    {2'd3, 32'h01020304, 32'h04030201}
  };

  // Reference: exact integer result clamped to the 8-bit signed range
  function automatic void model(input logic [1:0] o, input logic [VW-1:0] a,
                                input logic [VW-1:0] b, output logic [VW-1:0] r,
                                output logic [NL-1:0] s);
    r = '0; s = '0;
    for (int i = 0; i < NL; i++) begin
      int x = $signed(a[i*LW +: LW]);
      int y = $signed(b[i*LW +: LW]);
      int v;
      case (o)
        2'd0: v = (x < 0) ? -x : x;
        2'd1: v = -x;
        2'd2: v = x + y;
        default: v = x - y;
      endcase
      if (v > 127)  begin v = 127;  s[i] = 1'b1; end
      if (v < -128) begin v = -128; s[i] = 1'b1; end
      r[i*LW +: LW] = v[LW-1:0];
    end
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic clr);
    @(negedge clk);
    op = o; src_a = a; src_b = b; in_valid = 1'b1; flag_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] er;
    logic [NL-1:0] es;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 result", res_q, 0);
    chk("R10 lane_sat", lane_sat_q, 0);
    chk("R10 sticky", sat_sticky, 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R8
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][65:64], VEC[k][63:32], VEC[k][31:0], 1'b0);
      model(VEC[k][65:64], VEC[k][63:32], VEC[k][31:0], er, es);
      if (es != 0) exp_sticky = 1'b1;
      chk("R1-R5 lane result", res_q, er);
      chk("R6 lane_sat", lane_sat_q, es);
      chk("R8 sticky", sat_sticky, exp_sticky);
    end

    // R2 explicit: abs of 0x80 in lane 2 only
    apply(2'd0, 32'h00800000, 32'h0, 1'b0);
    chk("R2 abs min", res_q, 32'h007F0000);
    chk("R2 lane bit", lane_sat_q, 4'b0100);

    // R4 explicit: positive overflow -> 7F, negative -> 80
    apply(2'd2, 32'h0000807F, 32'h0000FF01, 1'b0);
    chk("R4 add clamp", res_q, 32'h0000807F);
    chk("R4 lane bits", lane_sat_q, 4'b0011);

    // R7 hold while valid low
    @(negedge clk);
    op = 2'd1; src_a = 32'h11223344; src_b = 32'h0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold result", res_q, 32'h0000807F);
    chk("R7 hold lane_sat", lane_sat_q, 4'b0011);

    // R8 non-saturating op keeps flag set
    apply(2'd2, 32'h01010101, 32'h01010101, 1'b0);
    chk("R8 result", res_q, 32'h02020202);
    chk("R8 flag kept", sat_sticky, 1);

    // R9 clear alone
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 cleared", sat_sticky, 0);
    chk("R9 result untouched", res_q, 32'h02020202);

    // R9 clear with saturating op in the same cycle: set wins
    apply(2'd1, 32'h00000080, 32'h0, 1'b1);
    chk("R9 set wins", sat_sticky, 1);
    chk("R3 neg min", res_q, 32'h0000007F);

    // R9 clear with non-saturating op: cleared
    apply(2'd1, 32'h00000005, 32'h0, 1'b1);
    chk("R9 clear with clean op", sat_sticky, 0);
    chk("R3 neg plain", res_q, 32'h000000FB);

    // R10 reset mid-run
    apply(2'd3, 32'h00000080, 32'h00000001, 1'b0);
    chk("R5 sub clamp", res_q, 32'h00000080);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 mid result", res_q, 0);
    chk("R10 mid sticky", sat_sticky, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule